// File: doc/BRIEF.md
# Interrupt moderation delay timers

This block holds back receive and transmit interrupts of a packet DMA engine so that several completed packets can share one interrupt. Each direction owns two countdown timers. The packet timer is reloaded by every qualifying completion, so it fires only after traffic has been quiet for a while. The absolute timer is started by the first qualifying completion and is not restarted by later ones, so it puts an upper bound on the total wait. Both timers count in units of a prescaler tick that runs freely, one tick every `TICK_DIV` clocks. With the default value at 250 MHz, one tick is 1.024 us.

Besides the timers, the block produces two causes that fire at once on each receive completion. One is a small-packet cause, raised when the length is at or below a programmable limit. The other is a descriptor-shortage cause, raised when the count of free descriptors left in the ring has dropped to a selected fraction of the ring length. A read of the receive delay register with its flush bit set forces a receive timer cause at once, and the block returns a strobe that clears that flag. When the interrupt line is actually asserted, every running timer is cancelled, and each cancelled direction reports its cause at that moment.

All cause outputs are registered one-cycle pulses. The interrupt cause register that lies outside the block collects them.

Top module: `intr_delay_timers`

## Requirements
- R1: A receive completion (`rx_done`) with nonzero `rx_pkt_delay` loads the receive packet timer with that count, even when the timer is already running. The timer then expires on the Nth prescaler tick after the load, and the expiry raises `cause_rxt` for exactly one cycle.
- R2: The receive absolute timer is loaded from `rx_abs_delay` only when both `rx_abs_delay` and `rx_pkt_delay` are nonzero and the timer is idle. Later completions do not restart it, and its expiry also raises `cause_rxt`.
- R3: Transmit timers are armed only by a `tx_done` that has `tx_ide` high. Their rules match R1 and R2, using `tx_pkt_delay` and `tx_abs_delay`, and their expiry raises `cause_txdw`.
- R4: A receive completion with `rx_len` <= `small_thresh` raises `cause_srpd` in the next cycle.
- R5: On a receive completion, `cause_rxdmt` pulses in the next cycle when `desc_left` * 2, * 4 or * 8 is <= `ring_len`, for `dmt_sel` = 0, 1 or 2 respectively. A `dmt_sel` of 3 never raises it.
- R6: A `rd_flush` strobe raises `cause_rxt` and `flush_clear` together in the next cycle.
- R7: `irq_assert` stops every running timer. In the next cycle, `cause_rxt` pulses if a receive timer was running and `cause_txdw` pulses if a transmit timer was running. Cancelled timers never expire later, and with no timer running `irq_assert` raises no cause.
- R8: The prescaler ticks once every `TICK_DIV` clocks. Counting clock edges after reset as 1, 2, ..., tick edges are the multiples of `TICK_DIV`. After reset every output is low.
- R9: A zero packet delay arms neither timer of its direction, whatever the absolute value is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | One-cycle receive completion strobe |
| rx_len | input | LEN_W | Length of the completed receive packet |
| rx_pkt_delay | input | 16 | Receive packet timer count, in ticks |
| rx_abs_delay | input | 16 | Receive absolute timer count, in ticks |
| small_thresh | input | LEN_W | Small-packet length limit |
| dmt_sel | input | 2 | Descriptor-shortage fraction select |
| ring_len | input | RING_W | Receive ring length in descriptors |
| desc_left | input | RING_W | Free descriptors remaining in the ring |
| tx_done | input | 1 | One-cycle transmit completion strobe |
| tx_ide | input | 1 | Delay-enable flag of the completed transmit descriptor |
| tx_pkt_delay | input | 16 | Transmit packet timer count, in ticks |
| tx_abs_delay | input | 16 | Transmit absolute timer count, in ticks |
| rd_flush | input | 1 | Delay register read while the flush flag is set |
| irq_assert | input | 1 | Interrupt line being asserted this cycle |
| cause_rxt | output | 1 | Receive timer cause pulse |
| cause_txdw | output | 1 | Transmit written-back cause pulse |
| cause_srpd | output | 1 | Small receive packet cause pulse |
| cause_rxdmt | output | 1 | Descriptor-shortage cause pulse |
| flush_clear | output | 1 | Strobe that clears the flush flag |

## Verification
On every cycle, the assertions check the following. A reload leaves the packet timer holding the new count. A running absolute timer ignores a new start. A cancel leaves the timer idle. Prescaler ticks never occur back to back. The small-packet and shortage causes appear only after a completion, and the flush strobe always produces its two outputs. Only the bench scenarios can show the exact expiry cycle. They measure it against a tick grid computed in the bench, and they contrast back-to-back packets that restart the packet timer with ones that leave the absolute timer alone. They also show that cancelled timers stay silent afterwards, and they sweep every ring fill level under each fraction code.

// File: rtl/imd_pkg.sv
package imd_pkg;

    localparam int TMR_W = 16;

    typedef enum logic [1:0] {
        DMT_HALF    = 2'd0,
        DMT_QUARTER = 2'd1,
        DMT_EIGHTH  = 2'd2,
        DMT_OFF     = 2'd3
    } dmt_sel_e;

    typedef struct packed {
        logic rxt;
        logic txdw;
        logic srpd;
        logic rxdmt;
    } cause_t;

    // true when remaining descriptors fall to or below the selected fraction
    function automatic logic ring_short(input dmt_sel_e sel,
                                        input logic [31:0] left,
                                        input logic [31:0] len);
        logic [35:0] scaled;
        scaled = {4'd0, left} << (32'(sel) + 1);
        if (sel == DMT_OFF) return 1'b0;
        return scaled <= {4'd0, len};
    endfunction

endpackage

// File: rtl/imd_prescaler.sv
module imd_prescaler #(
    parameter int DIV = 256
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CW'(1);
    end

    // R8: a tick never repeats on the following cycle
    p_tick_gap_r8: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick)
        else $error("prescaler ticked on consecutive cycles");

endmodule

// File: rtl/imd_timer.sv
module imd_timer #(
    parameter int W       = 16,
    parameter bit RESTART = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         start,
    input  logic [W-1:0] load_val,
    input  logic         cancel,
    output logic         running,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic         take;

    assign take   = start && (RESTART || !running);
    assign expire = running && tick && (cnt == W'(1)) && !take && !cancel;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (take) begin
            running <= 1'b1;
            cnt     <= load_val;
        end else if (cancel) begin
            running <= 1'b0;
        end else if (running && tick) begin
            if (cnt == W'(1)) running <= 1'b0;
            cnt <= cnt - W'(1);
        end
    end

    // R1: a restartable timer always takes the new count
    p_load_r1: assert property (@(posedge clk) disable iff (rst)
        (RESTART && start) |=> (running && cnt == $past(load_val)))
        else $error("packet timer did not reload");

    // R2: a running absolute timer keeps its count across a new start
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!RESTART && start && running && !tick && !cancel) |=> (cnt == $past(cnt)))
        else $error("absolute timer restarted");

    // R7: cancel leaves the timer idle
    p_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (cancel && !start) |=> !running)
        else $error("timer survived cancel");

endmodule

// File: rtl/imd_dir.sv
module imd_dir #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         arm,
    input  logic [W-1:0] pkt_val,
    input  logic [W-1:0] abs_val,
    input  logic         cancel,
    output logic         cause
);
    logic pkt_start, abs_start;
    logic pkt_run, abs_run, pkt_exp, abs_exp;

    assign pkt_start = arm && (pkt_val != '0);
    assign abs_start = pkt_start && (abs_val != '0);

    imd_timer #(.W(W), .RESTART(1'b1)) u_pkt (
        .clk(clk), .rst(rst), .tick(tick), .start(pkt_start),
        .load_val(pkt_val), .cancel(cancel),
        .running(pkt_run), .expire(pkt_exp)
    );

    imd_timer #(.W(W), .RESTART(1'b0)) u_abs (
        .clk(clk), .rst(rst), .tick(tick), .start(abs_start),
        .load_val(abs_val), .cancel(cancel),
        .running(abs_run), .expire(abs_exp)
    );

    assign cause = pkt_exp || abs_exp || (cancel && (pkt_run || abs_run));

    // R9: the absolute timer never runs without the packet timer having been armed
    p_abs_needs_pkt_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(abs_run) |-> $past(pkt_start))
        else $error("absolute timer started without packet delay");

endmodule

// File: rtl/intr_delay_timers.sv
module intr_delay_timers
    import imd_pkg::*;
#(
    parameter int TICK_DIV = 256,
    parameter int LEN_W    = 16,
    parameter int RING_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_done,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [TMR_W-1:0]  rx_pkt_delay,
    input  logic [TMR_W-1:0]  rx_abs_delay,
    input  logic [LEN_W-1:0]  small_thresh,
    input  logic [1:0]        dmt_sel,
    input  logic [RING_W-1:0] ring_len,
    input  logic [RING_W-1:0] desc_left,
    input  logic              tx_done,
    input  logic              tx_ide,
    input  logic [TMR_W-1:0]  tx_pkt_delay,
    input  logic [TMR_W-1:0]  tx_abs_delay,
    input  logic              rd_flush,
    input  logic              irq_assert,
    output logic              cause_rxt,
    output logic              cause_txdw,
    output logic              cause_srpd,
    output logic              cause_rxdmt,
    output logic              flush_clear
);
    logic   tick;
    logic   rx_cause, tx_cause;
    cause_t nxt, q;
    logic   flush_q;

    imd_prescaler #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    imd_dir #(.W(TMR_W)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .arm(rx_done),
        .pkt_val(rx_pkt_delay), .abs_val(rx_abs_delay),
        .cancel(irq_assert), .cause(rx_cause)
    );

    imd_dir #(.W(TMR_W)) u_tx (
        .clk(clk), .rst(rst), .tick(tick), .arm(tx_done && tx_ide),
        .pkt_val(tx_pkt_delay), .abs_val(tx_abs_delay),
        .cancel(irq_assert), .cause(tx_cause)
    );

    always_comb begin
        nxt       = '0;
        nxt.rxt   = rx_cause || rd_flush;
        nxt.txdw  = tx_cause;
        nxt.srpd  = rx_done && (rx_len <= small_thresh);
        nxt.rxdmt = rx_done && ring_short(dmt_sel_e'(dmt_sel),
                                          32'(desc_left), 32'(ring_len));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            flush_q <= 1'b0;
        end else begin
            q       <= nxt;
            flush_q <= rd_flush;
        end
    end

    assign cause_rxt   = q.rxt;
    assign cause_txdw  = q.txdw;
    assign cause_srpd  = q.srpd;
    assign cause_rxdmt = q.rxdmt;
    assign flush_clear = flush_q;

    // R4: the small-packet cause only follows a receive completion
    p_srpd_src_r4: assert property (@(posedge clk) disable iff (rst)
        cause_srpd |-> $past(rx_done))
        else $error("small-packet cause without completion");

    // R5: the shortage cause needs a completion and an enabled select
    p_dmt_src_r5: assert property (@(posedge clk) disable iff (rst)
        cause_rxdmt |-> ($past(rx_done) && $past(dmt_sel) != 2'd3))
        else $error("shortage cause raised while disabled");

    // R6: a flush read yields both the cause and the clear strobe
    p_flush_r6: assert property (@(posedge clk) disable iff (rst)
        rd_flush |=> (cause_rxt && flush_clear))
        else $error("flush read lost");

endmodule

// File: tb/sim_intr_delay_timers.sv
module sim_intr_delay_timers;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_done = 1'b0, tx_done = 1'b0, tx_ide = 1'b0;
    logic [7:0]  rx_len = 8'd200, small_thresh = 8'd0;
    logic [15:0] rx_pkt_delay = '0, rx_abs_delay = '0;
    logic [15:0] tx_pkt_delay = '0, tx_abs_delay = '0;
    logic [1:0]  dmt_sel = 2'd3;
    logic [7:0]  ring_len = 8'd16, desc_left = 8'd16;
    logic        rd_flush = 1'b0, irq_assert = 1'b0;
    logic        cause_rxt, cause_txdw, cause_srpd, cause_rxdmt, flush_clear;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    intr_delay_timers #(.TICK_DIV(DIV), .LEN_W(8), .RING_W(8)) u0 (
        .clk(clk), .rst(rst), .rx_done(rx_done), .rx_len(rx_len),
        .rx_pkt_delay(rx_pkt_delay), .rx_abs_delay(rx_abs_delay),
        .small_thresh(small_thresh), .dmt_sel(dmt_sel), .ring_len(ring_len),
        .desc_left(desc_left), .tx_done(tx_done), .tx_ide(tx_ide),
        .tx_pkt_delay(tx_pkt_delay), .tx_abs_delay(tx_abs_delay),
        .rd_flush(rd_flush), .irq_assert(irq_assert),
        .cause_rxt(cause_rxt), .cause_txdw(cause_txdw), .cause_srpd(cause_srpd),
        .cause_rxdmt(cause_rxdmt), .flush_clear(flush_clear)
    );

    function automatic int exp_at(input int ld, input int v);
        return ((ld / DIV) + 1) * DIV + (v - 1) * DIV;
    endfunction

    function automatic logic sig(input int sel);
        return (sel == 0) ? cause_rxt : cause_txdw;
    endfunction

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // drive completions at a negedge; returns the edge number that samples them
    task automatic fire(input bit rx, input bit tx, input bit ide, output int ld);
        rx_done = rx; tx_done = tx; tx_ide = ide;
        ld = cyc + 1;
        @(negedge clk);
        rx_done = 1'b0; tx_done = 1'b0; tx_ide = 1'b0;
    endtask

    task automatic wait_sig(input int sel, input int maxc, output int at);
        at = -1;
        for (int i = 0; i < maxc; i++) begin
            if (sig(sel)) begin
                at = cyc;
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic quiesce();
        irq_assert = 1'b1;
        @(negedge clk);
        irq_assert = 1'b0;
        idle(3);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int l1, l2, at;
        idle(4);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        check(int'({cause_rxt, cause_txdw, cause_srpd, cause_rxdmt, flush_clear}), 0, "R8 reset");

        // R1: single packet timer expiry on the tick grid
        rx_pkt_delay = 16'd3;
        fire(1, 0, 0, l1);
        wait_sig(0, 100, at);
        check(at, exp_at(l1, 3), "R1 single expiry");
        @(negedge clk);
        check(int'(cause_rxt), 0, "R1 one-cycle pulse");
        idle(2);

        // R1: back-to-back packets reload the packet timer
        rx_pkt_delay = 16'd5;
        fire(1, 0, 0, l1);
        idle(6);
        fire(1, 0, 0, l2);
        wait_sig(0, 100, at);
        check(at, exp_at(l2, 5), "R1 reload on second packet");
        quiesce();

        // R2: absolute timer keeps the first start
        rx_pkt_delay = 16'd20; rx_abs_delay = 16'd4;
        fire(1, 0, 0, l1);
        idle(6);
        fire(1, 0, 0, l2);
        wait_sig(0, 200, at);
        check(at, exp_at(l1, 4), "R2 absolute not restarted");
        @(negedge clk);
        wait_sig(0, 200, at);
        check(at, exp_at(l2, 20), "R2 packet timer after absolute");
        quiesce();

        // R9: zero packet delay arms nothing
        rx_pkt_delay = 16'd0; rx_abs_delay = 16'd3;
        fire(1, 0, 0, l1);
        wait_sig(0, 60, at);
        check(at, -1, "R9 no receive timer");
        rx_abs_delay = 16'd0;

        // R3: transmit timers gated by the delay-enable flag
        tx_pkt_delay = 16'd2;
        fire(0, 1, 0, l1);
        wait_sig(1, 40, at);
        check(at, -1, "R3 flag clear ignored");
        fire(0, 1, 1, l1);
        wait_sig(1, 60, at);
        check(at, exp_at(l1, 2), "R3 transmit packet timer");
        idle(2);
        tx_pkt_delay = 16'd20; tx_abs_delay = 16'd3;
        fire(0, 1, 1, l1);
        idle(5);
        fire(0, 1, 1, l2);
        wait_sig(1, 200, at);
        check(at, exp_at(l1, 3), "R3 transmit absolute not restarted");
        @(negedge clk);
        wait_sig(1, 200, at);
        check(at, exp_at(l2, 20), "R3 transmit packet reload");
        idle(2);

        // R7: interrupt assertion cancels and reports both directions
        rx_pkt_delay = 16'd30; tx_pkt_delay = 16'd30; tx_abs_delay = 16'd0;
        fire(1, 1, 1, l1);
        idle(3);
        irq_assert = 1'b1;
        l2 = cyc + 1;
        @(negedge clk);
        irq_assert = 1'b0;
        check(int'(cause_rxt), 1, "R7 receive cancel reported");
        check(int'(cause_txdw), 1, "R7 transmit cancel reported");
        check(cyc, l2, "R7 cancel cycle");
        @(negedge clk);
        wait_sig(0, 200, at);
        check(at, -1, "R7 receive stays silent");
        wait_sig(1, 10, at);
        check(at, -1, "R7 transmit stays silent");
        irq_assert = 1'b1;
        @(negedge clk);
        irq_assert = 1'b0;
        check(int'({cause_rxt, cause_txdw}), 0, "R7 idle cancel no cause");
        rx_pkt_delay = '0; tx_pkt_delay = '0;

        // R6: flush read
        rd_flush = 1'b1;
        @(negedge clk);
        rd_flush = 1'b0;
        check(int'({cause_rxt, flush_clear}), 3, "R6 flush cause and clear");
        @(negedge clk);
        check(int'({cause_rxt, flush_clear}), 0, "R6 single pulse");

        // R4: small-packet boundary
        small_thresh = 8'd64;
        for (int len = 62; len <= 66; len++) begin
            rx_len = 8'(len);
            fire(1, 0, 0, l1);
            check(int'(cause_srpd), (len <= 64) ? 1 : 0, "R4 small packet");
        end
        small_thresh = 8'd0; rx_len = 8'd200;

        // R5: sweep fill levels for every select code and two ring sizes
        for (int r = 0; r < 2; r++) begin
            ring_len = (r == 0) ? 8'd16 : 8'd24;
            for (int c = 0; c < 4; c++) begin
                dmt_sel = 2'(c);
                for (int lft = 0; lft <= int'(ring_len); lft++) begin
                    desc_left = 8'(lft);
                    fire(1, 0, 0, l1);
                    check(int'(cause_rxdmt),
                          (c == 3) ? 0 : ((lft * (2 << c) <= int'(ring_len)) ? 1 : 0),
                          "R5 descriptor shortage");
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule